// File: doc/BRIEF.md
# Macro Execute Unit

This block is the execute stage of a small macro processor. Each cycle it receives a 32-bit instruction word and two 32-bit register operands, A and B, and it produces a 32-bit result combinationally. The low three bits of the instruction select an operation class. The classes it handles are:

- a register-register ALU class, with add, subtract, their carry-chained variants and five logic operations;
- an add-immediate class;
- three bit-field classes. Each takes a field of a given width out of B at one position and places it at another.

The block keeps one carry flag between instructions. It is written only when an instruction is strobed by `op_en` and that instruction is one of the four arithmetic ALU operations. This lets a sequence of add-with-carry or subtract-with-borrow instructions build wider arithmetic. Fetch, branching, memory reads and the dispatch of results to registers belong to the surrounding processor. For the classes used by those parts, this unit returns zero.

Top module: `macro_exec_unit`

## Requirements
- R1: The operation class is `instr[2:0]`. Class 0 is the ALU class, and its function code is `instr[21:17]`. Code 0 returns A + B modulo 2^32 and writes the carry-out of bit 31 into the carry flag.
- R2: ALU code 1 returns A + B + carry and writes its carry-out into the carry flag.
- R3: ALU code 2 returns A - B, and code 3 returns A - B - (1 - carry). Both write the no-borrow bit into the carry flag: 1 when the unsigned minuend is at least the subtrahend plus the borrow, 0 otherwise.
- R4: ALU codes 8 to 12 return, in turn, A xor B, A or B, A and B, A and not B, and not (A and B).
- R5: ALU codes 4 to 7 and 13 to 31 are invalid. With an invalid code, `illegal` is 1, `result` is 0 and the carry flag is not written. `illegal` is 0 for every valid ALU code and for every other class.
- R6: The carry flag is 0 after reset. It changes only on a rising clock edge with `op_en` high while a class-0 instruction with code 0 to 3 is presented. The flag is visible on `carry`.
- R7: Class 1 returns A plus the 18-bit immediate `instr[31:14]`, sign-extended to 32 bits.
- R8: For the bit-field classes, the field width is `instr[26:22]`, the source position is `instr[21:17]`, the destination position is `instr[31:27]`, and the field mask is (1 << width) - 1. A width of 0 selects an empty field.
- R9: Class 2 takes F = (B >> source) & mask. It returns A with the bits of mask << destination cleared and F << destination ORed in, truncated to 32 bits.
- R10: Class 3 takes F = (B >> A[4:0]) & mask and returns F << destination. The source position comes from the low five bits of A, and the instruction's source field is ignored.
- R11: Class 4 takes F = (B >> source) & mask and returns F << A[4:0]. The shift comes from the low five bits of A, and the instruction's destination field is ignored.
- R12: Classes 5, 6 and 7 return 0 with `illegal` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the carry flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Instruction is executed this cycle (allows the carry write) |
| instr | input | 32 | Instruction word |
| opnd_a | input | 32 | Source operand A |
| opnd_b | input | 32 | Source operand B |
| result | output | 32 | Combinational result |
| illegal | output | 1 | Invalid ALU function code presented |
| carry | output | 1 | Current carry flag |

## Verification
The hardest situation to reach is a carry-chained operation that starts from a known carry state. That state is left behind by whichever instruction happened to run before. The bench keeps its own carry model and walks every function code against a grid of boundary operands: zero, one, all ones, the sign bit and mixed patterns. Because of this, add-with-carry and subtract-with-borrow each run with both carry values and right at the overflow edges. The bit-field classes are swept over every width and source position, across a spread of destinations. A is loaded with non-zero upper bits, so that only its low five bits can steer the register-driven position.

// File: rtl/macro_exec_pkg.sv
package macro_exec_pkg;

    localparam int unsigned DW    = 32;
    localparam int unsigned POS_W = $clog2(DW);
    localparam int unsigned IMM_W = 18;

    typedef enum logic [2:0] {
        CLS_ALU     = 3'd0,
        CLS_ADDI    = 3'd1,
        CLS_INSERT  = 3'd2,
        CLS_SHL_IMM = 3'd3,
        CLS_SHL_REG = 3'd4,
        CLS_LOAD    = 3'd5,
        CLS_RSVD    = 3'd6,
        CLS_JUMP    = 3'd7
    } op_class_e;

    localparam logic [4:0] FN_ADD  = 5'd0;
    localparam logic [4:0] FN_ADC  = 5'd1;
    localparam logic [4:0] FN_SUB  = 5'd2;
    localparam logic [4:0] FN_SBB  = 5'd3;
    localparam logic [4:0] FN_XOR  = 5'd8;
    localparam logic [4:0] FN_OR   = 5'd9;
    localparam logic [4:0] FN_AND  = 5'd10;
    localparam logic [4:0] FN_ANDN = 5'd11;
    localparam logic [4:0] FN_NAND = 5'd12;

    typedef struct packed {
        op_class_e        cls;
        logic [4:0]       fn;
        logic [POS_W-1:0] src_pos;
        logic [POS_W-1:0] width;
        logic [POS_W-1:0] dst_pos;
        logic [IMM_W-1:0] imm;
    } instr_fields_t;

    typedef struct packed {
        logic carry;
    } exec_state_t;

    function automatic instr_fields_t decode_instr(input logic [DW-1:0] w);
        instr_fields_t f;
        f.cls     = op_class_e'(w[2:0]);
        f.fn      = w[21:17];
        f.src_pos = w[21:17];
        f.width   = w[26:22];
        f.dst_pos = w[31:27];
        f.imm     = w[31:14];
        return f;
    endfunction

endpackage

// File: rtl/macro_alu_core.sv
module macro_alu_core
    import macro_exec_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [4:0]       fn,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] res,
    output logic             carry_out,
    output logic             writes_carry,
    output logic             bad_fn
);

    logic [WIDTH:0] sum;

    always_comb begin
        sum          = '0;
        res          = '0;
        carry_out    = 1'b0;
        writes_carry = 1'b0;
        bad_fn       = 1'b0;
        case (fn)
            FN_ADD: begin
                sum          = {1'b0, a} + {1'b0, b};
                writes_carry = 1'b1;
            end
            FN_ADC: begin
                sum          = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, carry_in};
                writes_carry = 1'b1;
            end
            FN_SUB: begin
                sum          = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1};
                writes_carry = 1'b1;
            end
            FN_SBB: begin
                sum          = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, carry_in};
                writes_carry = 1'b1;
            end
            FN_XOR:  sum = {1'b0, a ^ b};
            FN_OR:   sum = {1'b0, a | b};
            FN_AND:  sum = {1'b0, a & b};
            FN_ANDN: sum = {1'b0, a & ~b};
            FN_NAND: sum = {1'b0, ~(a & b)};
            default: bad_fn = 1'b1;
        endcase
        res       = sum[WIDTH-1:0];
        carry_out = sum[WIDTH];
    end

endmodule

// File: rtl/macro_field_unit.sv
module macro_field_unit #(
    parameter int unsigned WIDTH = 32,
    parameter bit          MERGE = 1'b0
) (
    input  logic [$clog2(WIDTH)-1:0] src_pos,
    input  logic [$clog2(WIDTH)-1:0] field_w,
    input  logic [$clog2(WIDTH)-1:0] dst_shift,
    input  logic [WIDTH-1:0]         base,
    input  logic [WIDTH-1:0]         b,
    output logic [WIDTH-1:0]         res
);

    logic [WIDTH-1:0] mask;
    logic [WIDTH-1:0] field;
    logic [WIDTH-1:0] placed;
    logic [WIDTH-1:0] hole;

    always_comb begin
        mask   = (WIDTH'(1) << field_w) - WIDTH'(1);
        field  = (b >> src_pos) & mask;
        placed = field << dst_shift;
        hole   = ~(mask << dst_shift);
    end

    generate
        if (MERGE) begin : g_merge
            assign res = (base & hole) | placed;
        end else begin : g_plain
            assign res = placed;
        end
    endgenerate

endmodule

// File: rtl/macro_exec_unit.sv
module macro_exec_unit
    import macro_exec_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_en,
    input  logic [31:0]   instr,
    input  logic [31:0]   opnd_a,
    input  logic [31:0]   opnd_b,
    output logic [31:0]   result,
    output logic          illegal,
    output logic          carry
);

    localparam int unsigned N_FORMS = 3;

    instr_fields_t    dec;
    exec_state_t      state_d, state_q;

    logic [DW-1:0]    alu_res;
    logic             alu_cout;
    logic             alu_wc;
    logic             alu_bad;
    logic [DW-1:0]    imm_ext;
    logic [DW-1:0]    field_res [N_FORMS];

    assign dec     = decode_instr(instr);
    assign imm_ext = {{(DW-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};

    macro_alu_core #(.WIDTH(DW)) u_alu (
        .fn           (dec.fn),
        .a            (opnd_a),
        .b            (opnd_b),
        .carry_in     (state_q.carry),
        .res          (alu_res),
        .carry_out    (alu_cout),
        .writes_carry (alu_wc),
        .bad_fn       (alu_bad)
    );

    // form 0: insert at fixed positions, form 1: source position from A,
    // form 2: destination shift from A
    generate
        for (genvar gi = 0; gi < N_FORMS; gi++) begin : g_form
            logic [POS_W-1:0] src_sel;
            logic [POS_W-1:0] sh_sel;
            assign src_sel = (gi == 1) ? opnd_a[POS_W-1:0] : dec.src_pos;
            assign sh_sel  = (gi == 2) ? opnd_a[POS_W-1:0] : dec.dst_pos;
            macro_field_unit #(.WIDTH(DW), .MERGE(gi == 0)) u_field (
                .src_pos   (src_sel),
                .field_w   (dec.width),
                .dst_shift (sh_sel),
                .base      (opnd_a),
                .b         (opnd_b),
                .res       (field_res[gi])
            );
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        result  = '0;
        illegal = 1'b0;
        case (dec.cls)
            CLS_ALU: begin
                result  = alu_bad ? '0 : alu_res;
                illegal = alu_bad;
                if (op_en && alu_wc) begin
                    state_d.carry = alu_cout;
                end
            end
            CLS_ADDI:    result = opnd_a + imm_ext;
            CLS_INSERT:  result = field_res[0];
            CLS_SHL_IMM: result = field_res[1];
            CLS_SHL_REG: result = field_res[2];
            default:     result = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign carry = state_q.carry;

endmodule

// File: rtl/macro_exec_checker.sv
module macro_exec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        op_en,
    input logic [31:0] instr,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [31:0] result,
    input logic        illegal,
    input logic        carry
);

    logic [2:0] cls;
    logic [4:0] fn;
    logic [4:0] wid;
    assign cls = instr[2:0];
    assign fn  = instr[21:17];
    assign wid = instr[26:22];

    // R5: an invalid code yields a zero result
    p_illegal_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> result == 32'd0);

    // R5: an invalid code leaves the carry flag untouched
    p_illegal_keeps_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && op_en) |=> carry == $past(carry));

    // R6: without a strobe the carry flag holds
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !op_en |=> $stable(carry));

    // R6: non-ALU classes never write the carry flag
    p_class_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cls != 3'd0) |=> $stable(carry));

    // R3: subtracting equal operands gives zero and sets no-borrow
    p_sub_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && cls == 3'd0 && fn == 5'd2 && opnd_a == opnd_b) |=> carry);

    // R4: and-not never sets a bit absent from A
    p_andn_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == 3'd0 && fn == 5'd11) |-> (result & ~opnd_a) == 32'd0);

    // R8: empty field in the shift forms gives zero
    p_empty_field_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cls == 3'd3 || cls == 3'd4) && wid == 5'd0) |-> result == 32'd0);

    // R12: classes outside this unit return zero
    p_foreign_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cls >= 3'd5) |-> (result == 32'd0 && !illegal));

endmodule

bind macro_exec_unit macro_exec_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_en   (op_en),
    .instr   (instr),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .result  (result),
    .illegal (illegal),
    .carry   (carry)
);

// File: tb/sim_macro_exec_unit.sv
module sim_macro_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_en;
    logic [31:0] instr;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [31:0] result;
    logic        illegal;
    logic        carry;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic model_c;

    always #10 clk = ~clk;

    macro_exec_unit u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_en   (op_en),
        .instr   (instr),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .result  (result),
        .illegal (illegal),
        .carry   (carry)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic en, input logic [31:0] w,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_en  = en;
        instr  = w;
        opnd_a = a;
        opnd_b = b;
        #1;
    endtask

    function automatic logic [31:0] w_alu(input logic [4:0] fn);
        return {10'd0, fn, 14'd0, 3'd0};
    endfunction

    function automatic logic [31:0] w_bf(input logic [2:0] c, input int s,
                                         input int wd, input int d);
        return {5'(d), 5'(wd), 5'(s), 14'h2A5A, c};
    endfunction

    function automatic logic [31:0] fmask(input int wd);
        return (wd == 0) ? 32'd0 : (32'hFFFF_FFFF >> (32 - wd));
    endfunction

    logic [31:0] pats [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                              32'h7FFF_FFFF, 32'h1234_5678, 32'hFFFF_FFFE, 32'hA5A5_0F0F};

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op_en = 1'b0; instr = '0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R6 reset carry", {31'd0, carry}, 32'd0);
        model_c = 1'b0;

        // ALU sweep over every function code with boundary operands (R1..R5)
        for (int fn = 0; fn < 32; fn++) begin
            for (int ia = 0; ia < 8; ia++) begin
                for (int ib = 0; ib < 8; ib++) begin
                    logic [31:0] a, b, er;
                    logic ec, eu, ei, bw;
                    logic [63:0] s;
                    string tag;
                    a = pats[ia]; b = pats[ib];
                    er = '0; ec = 1'b0; eu = 1'b0; ei = 1'b0;
                    bw = ~model_c;
                    case (fn)
                        0: begin s = 64'(a) + 64'(b); er = s[31:0]; ec = s[32]; eu = 1; tag = "R1"; end
                        1: begin s = 64'(a) + 64'(b) + 64'(model_c); er = s[31:0]; ec = s[32]; eu = 1; tag = "R2"; end
                        2: begin er = a - b; ec = (a >= b); eu = 1; tag = "R3"; end
                        3: begin er = a - b - 32'(bw); ec = (64'(a) >= 64'(b) + 64'(bw)); eu = 1; tag = "R3"; end
                        8:  begin er = a ^ b;    tag = "R4"; end
                        9:  begin er = a | b;    tag = "R4"; end
                        10: begin er = a & b;    tag = "R4"; end
                        11: begin er = a & ~b;   tag = "R4"; end
                        12: begin er = ~(a & b); tag = "R4"; end
                        default: begin ei = 1; tag = "R5"; end
                    endcase
                    apply(1'b1, w_alu(5'(fn)), a, b);
                    chk({tag, " result"}, result, er);
                    chk("R5 illegal flag", {31'd0, illegal}, {31'd0, ei});
                    if (eu) model_c = ec;
                    @(posedge clk); #1;
                    chk({tag, " R6 carry"}, {31'd0, carry}, {31'd0, model_c});
                end
            end
        end

        // carry holds without strobe (R6)
        apply(1'b1, w_alu(5'd0), 32'hFFFF_FFFF, 32'h1);
        @(posedge clk); #1;
        chk("R6 carry set by add", {31'd0, carry}, 32'd1);
        apply(1'b0, w_alu(5'd2), 32'h0, 32'h1);
        @(posedge clk); #1;
        chk("R6 no strobe hold", {31'd0, carry}, 32'd1);
        apply(1'b1, w_alu(5'd8), 32'h0, 32'h0);
        @(posedge clk); #1;
        chk("R6 logic op hold", {31'd0, carry}, 32'd1);

        // add immediate (R7)
        for (int ia = 0; ia < 8; ia++) begin
            logic [17:0] imms [5] = '{18'h0, 18'h1, 18'h3FFFF, 18'h20000, 18'h1FFFF};
            for (int k = 0; k < 5; k++) begin
                logic [31:0] sx;
                sx = imms[k][17] ? {14'h3FFF, imms[k]} : {14'h0, imms[k]};
                apply(1'b1, {imms[k], 11'h5A5, 3'd1}, pats[ia], 32'hDEAD_BEEF);
                chk("R7 add immediate", result, pats[ia] + sx);
            end
        end

        // bit-field forms (R8..R11)
        for (int s = 0; s < 32; s++) begin
            for (int wd = 0; wd < 32; wd++) begin
                for (int d = 0; d < 32; d += ((d == 30) ? 1 : 5)) begin
                    logic [31:0] m, a, b, f;
                    logic [63:0] t;
                    m = fmask(wd);
                    a = 32'hC3A5_96F0;
                    b = 32'h9E37_79B9 ^ (32'(s) * 32'h0101_0101);
                    f = (b >> s) & m;
                    t = (64'(a) & ~(64'(m) << d)) | (64'(f) << d);
                    apply(1'b1, w_bf(3'd2, s, wd, d), a, b);
                    chk((wd == 0) ? "R8 empty insert" : "R9 insert", result, t[31:0]);
                    t = 64'(f) << d;
                    apply(1'b1, w_bf(3'd3, (s + 7) % 32, wd, d), {27'h5A5A5A5, 5'(s)}, b);
                    chk((wd == 0) ? "R8 empty shl imm" : "R10 shl imm", result, t[31:0]);
                    apply(1'b1, w_bf(3'd4, s, wd, (d + 3) % 32), {27'h3C3C3C3, 5'(d)}, b);
                    chk((wd == 0) ? "R8 empty shl reg" : "R11 shl reg", result, t[31:0]);
                end
            end
        end
        @(posedge clk); #1;
        chk("R6 bit-field keeps carry", {31'd0, carry}, 32'd1);

        // foreign classes (R12)
        for (int c = 5; c < 8; c++) begin
            apply(1'b1, {20'hFFFFF, 9'h1FF, 3'(c)}, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
            chk("R12 foreign result", result, 32'd0);
            chk("R12 foreign illegal", {31'd0, illegal}, 32'd0);
            @(posedge clk); #1;
            chk("R12 foreign carry", {31'd0, carry}, 32'd1);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule